// File: doc/BRIEF.md
# Tree Sum Reduction Engine

This block holds a bank of N integer partial sums and collapses them into one total by a halving tree. Before each fold the engine inspects the active count. When that count is odd, element 0 takes in the single unpaired top element. The count is then halved with truncation, and every element below the new count adds in its partner that sits exactly that many places higher. One fold is done per clock. All reads in a fold see the values from before that fold, and all writes land together on one edge. The next fold therefore never sees a half-updated bank.

Values reach the bank while the engine is idle, in one of two ways. A parallel load fills every element at once, and an indexed write fills a single element. A start pulse launches the reduction. When the last fold has committed, a one-cycle done pulse marks the total as valid on the `total` output, which always shows element 0. All additions are unsigned and wrap modulo 2^W.

Top module: `tree_sum_reduce`

## Requirements
- R1: After reset every element is zero: `total` reads 0, and both `busy` and `done` read 0.
- R2: While idle, `ld_all` high at a clock edge copies `ld_bus` into the bank. Element k is taken from bits [k*W +: W]. `ld_all` has priority over `wr_en`.
- R3: While idle, `wr_en` high writes `wr_data` into element `wr_idx` only. An index of N or more changes nothing. With no write and no load, the bank holds its values.
- R4: `start` sampled high while idle sets `busy` at that edge and makes the active count N.
- R5: Every addition wraps modulo 2^W.
- R6: In a fold where the active count is odd, element 0 also adds the element at index count-1. This happens in the same fold as its normal pairing.
- R7: `done` goes high S clock edges after the edge that accepted `start`, and `busy` falls with it. S is the number of truncating halvings that take N down to 1 (2 for N=7, log2(N) for a power-of-two N).
- R8: `done` is high for exactly one cycle per reduction.
- R9: `start` sampled while busy is ignored. The step count and the result are unchanged.
- R10: `ld_all` and `wr_en` are ignored while busy. The result is unchanged.
- R11: When `done` is high, `total` equals the wrapped sum of all N values held at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_all | input | 1 | Parallel load of the whole bank |
| ld_bus | input | N*W | Parallel load data; element k in bits [k*W +: W] |
| wr_en | input | 1 | Indexed write enable |
| wr_idx | input | $clog2(N) | Indexed write element number |
| wr_data | input | W | Indexed write data |
| start | input | 1 | Launch a reduction (idle only) |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse: total valid |
| total | output | W | Element 0 of the bank |

## Verification
A load or write becomes visible on `total` one edge after it is sampled. It shows there directly for element 0; for other elements it shows in the result of a later reduction. `done` and the final `total` appear S edges after the edge that accepted `start`. The bench counts edges from that accepting edge and samples 1 ns after each edge. It then looks one further edge ahead to confirm that `done` has dropped. A second instance with N=8 checks the power-of-two step count of 3.

// File: rtl/sumtree_pkg.sv
package sumtree_pkg;
  // active count after one fold (truncating halving)
  function automatic int unsigned next_active(input int unsigned a);
    return a >> 1;
  endfunction
  // element 0 takes the unpaired top element when the count is odd
  function automatic bit needs_tail(input int unsigned a);
    return a[0];
  endfunction
  // number of folds to reach one element
  function automatic int unsigned fold_steps(input int unsigned n);
    int unsigned a, s;
    a = n; s = 0;
    while (a > 1) begin a = a >> 1; s++; end
    return s;
  endfunction
endpackage

// File: rtl/sumtree_ctrl.sv
module sumtree_ctrl #(
  parameter int N  = 7,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] act
);
  import sumtree_pkg::*;
  logic [CW-1:0] act_nx;
  logic          last_fold;

  always_comb begin
    act_nx    = CW'(next_active(int'(act)));
    last_fold = busy && (act_nx <= CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      act  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          act  <= CW'(N);
        end
      end else begin
        act <= act_nx;
        if (last_fold) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sumtree_lane.sv
module sumtree_lane #(
  parameter int N   = 7,
  parameter int W   = 32,
  parameter int IDX = 0,
  parameter int CW  = $clog2(N + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic [CW-1:0]       act,
  input  logic                ld_all,
  input  logic [W-1:0]        ld_val,
  input  logic                wr_hit,
  input  logic [W-1:0]        wr_val,
  input  logic [N-1:0][W-1:0] bank,
  output logic [W-1:0]        q
);
  import sumtree_pkg::*;

  function automatic logic [W-1:0] pick(input logic [N-1:0][W-1:0] b,
                                        input int unsigned k);
    logic [W-1:0] r;
    r = '0;
    for (int j = 0; j < N; j++) if (k == j) r = b[j];
    return r;
  endfunction

  int unsigned  nh;
  logic         take;
  logic         tail_on;
  logic [W-1:0] partner_v, tail_v, fold_v;

  always_comb begin
    nh        = next_active(int'(act));
    take      = busy && (IDX < nh);
    partner_v = take ? pick(bank, IDX + nh) : '0;
  end

  generate
    if (IDX == 0) begin : g_head
      always_comb begin
        tail_on = busy && needs_tail(int'(act));
        tail_v  = tail_on ? pick(bank, int'(act) - 1) : '0;
      end
    end else begin : g_body
      always_comb begin
        tail_on = 1'b0;
        tail_v  = '0;
      end
    end
  endgenerate

  always_comb fold_v = q + partner_v + tail_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (busy) begin
      if (take || tail_on) q <= fold_v;
    end
    else if (ld_all)     q <= ld_val;
    else if (wr_hit)     q <= wr_val;
  end
endmodule

// File: rtl/tree_sum_reduce.sv
module tree_sum_reduce #(
  parameter int N = 7,
  parameter int W = 32,
  localparam int CW = $clog2(N + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_all,
  input  logic [N*W-1:0] ld_bus,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [W-1:0]   wr_data,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   total
);
  logic [N-1:0][W-1:0] bank;
  logic [CW-1:0]       act_cnt;

  sumtree_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .act(act_cnt)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      logic wr_hit;
      assign wr_hit = wr_en && (wr_idx == IW'(i));
      sumtree_lane #(.N(N), .W(W), .IDX(i), .CW(CW)) u_lane (
        .clk(clk), .rst_n(rst_n), .busy(busy), .act(act_cnt),
        .ld_all(ld_all), .ld_val(ld_bus[i*W +: W]),
        .wr_hit(wr_hit), .wr_val(wr_data),
        .bank(bank), .q(bank[i])
      );
    end
  endgenerate

  assign total = bank[0];
endmodule

// File: rtl/sumtree_chk.sv
module sumtree_chk #(
  parameter int N  = 7,
  parameter int W  = 32,
  parameter int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ld_all,
  input logic          wr_en,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  total,
  input logic [CW-1:0] act
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && act == CW'(N))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (act != CW'(N))); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !ld_all && !wr_en) |=> $stable(total)); // R3
endmodule

bind tree_sum_reduce sumtree_chk #(.N(N), .W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ld_all(ld_all), .wr_en(wr_en),
  .busy(busy), .done(done), .total(total), .act(act_cnt)
);

// File: tb/tb_tree_sum_reduce.sv
`timescale 1ns/1ps
module tb_tree_sum_reduce;
  localparam int N = 7, W = 32, IW = $clog2(N);
  localparam int STEPS = 2; // 7 -> 3 -> 1

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ld_all = 0, wr_en = 0, start = 0;
  logic [N*W-1:0] ld_bus = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [W-1:0] wr_data = '0;
  logic busy, done;
  logic [W-1:0] total;

  tree_sum_reduce #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .ld_all(ld_all), .ld_bus(ld_bus),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .start(start), .busy(busy), .done(done), .total(total));

  logic p_ld = 0, p_start = 0;
  logic [8*W-1:0] p_bus = '0;
  logic p_busy, p_done;
  logic [W-1:0] p_total;
  tree_sum_reduce #(.N(8), .W(W)) dut_p2 (
    .clk(clk), .rst_n(rst_n), .ld_all(p_ld), .ld_bus(p_bus),
    .wr_en(1'b0), .wr_idx(3'd0), .wr_data('0),
    .start(p_start), .busy(p_busy), .done(p_done), .total(p_total));

  // stimulus vectors with hand-computed sums
  typedef struct packed { logic [N*W-1:0] vals; logic [W-1:0] sum; } vec_t;
  localparam vec_t VECS [4] = '{
    '{ {32'd7,32'd6,32'd5,32'd4,32'd3,32'd2,32'd1}, 32'd28 },
    '{ {32'd700,32'd600,32'd500,32'd400,32'd300,32'd200,32'd100}, 32'd2800 },
    '{ {7{32'hFFFF_FFFF}}, 32'hFFFF_FFF9 },
    '{ {32'd5,32'd0,32'd0,32'd0,32'd1,32'h8000_0000,32'h8000_0000}, 32'd6 }
  };

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act_v,
                     input logic [W-1:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [W-1:0] ref_sum(input logic [N*W-1:0] v);
    logic [W-1:0] s = '0;
    for (int k = N - 1; k >= 0; k--) s = s + v[k*W +: W];
    return s;
  endfunction

  task automatic load(input logic [N*W-1:0] v);
    ld_bus = v; ld_all = 1;
    @(posedge clk); #1; ld_all = 0;
  endtask

  // launches a reduction; disturb = pulse start/ld/wr during the first busy cycle
  task automatic reduce(input bit disturb, output int cyc);
    start = 1;
    @(posedge clk); #1; start = 0;
    if (disturb) begin
      start = 1; ld_all = 1; ld_bus = '1; wr_en = 1; wr_idx = '0; wr_data = 32'd999;
    end
    cyc = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      start = 0; ld_all = 0; wr_en = 0;
      cyc++;
      if (done) break;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [N*W-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(total == 0, "R1 total", total, 0);
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // table walk: R2 R5 R6 R7 R8 R11
    foreach (VECS[i]) begin
      load(VECS[i].vals);
      chk(total == VECS[i].vals[W-1:0], "R2 load elem0", total, VECS[i].vals[W-1:0]);
      reduce(0, cyc);
      chk(cyc == STEPS && done, "R7 steps", cyc, STEPS);
      chk(total == VECS[i].sum, "R11/R6/R5 sum", total, VECS[i].sum);
      chk(total == ref_sum(VECS[i].vals), "R11 reference", total, ref_sum(VECS[i].vals));
      @(posedge clk); #1;
      chk(!done, "R8 done one cycle", done, 0);
    end

    // R3 indexed write to one element, out-of-range index ignored
    v = {32'd7,32'd6,32'd5,32'd4,32'd3,32'd2,32'd1};
    load(v);
    wr_en = 1; wr_idx = 3'd3; wr_data = 32'd1000;
    @(posedge clk); #1;
    wr_idx = 3'd7; wr_data = 32'd5000;
    @(posedge clk); #1; wr_en = 0;
    chk(total == 32'd1, "R3 elem0 untouched", total, 1);
    reduce(0, cyc);
    chk(total == 32'd1024, "R3 indexed write", total, 1024);

    // R6 odd tail: only the top element nonzero
    load({32'd77, {6{32'd0}}});
    reduce(0, cyc);
    chk(total == 32'd77, "R6 odd tail folded", total, 77);

    // R9 R10 start/load/write during busy ignored
    load(v);
    reduce(1, cyc);
    chk(cyc == STEPS, "R9 start ignored", cyc, STEPS);
    chk(total == 32'd28, "R10 writes ignored", total, 28);
    @(posedge clk); #1;
    chk(!busy && !done, "R9 no restart", {busy, done}, 0);

    // R7 power of two: N=8 takes log2(8)=3 steps
    for (int k = 0; k < 8; k++) p_bus[k*W +: W] = 32'(k + 1);
    p_ld = 1; @(posedge clk); #1; p_ld = 0;
    p_start = 1; @(posedge clk); #1; p_start = 0;
    cyc = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1; cyc++;
      if (p_done) break;
    end
    chk(cyc == 3, "R7 pow2 steps", cyc, 3);
    chk(p_total == 32'd36, "R11 pow2 sum", p_total, 36);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule